// File: doc/BRIEF.md
# Register Write Sequencer Engine

This block replays stored lists of control-register writes into a device's register file, so the host does not have to issue each write itself. A single command memory holds two regions in one location space. Locations 0 to 31 are RAM, preset at reset and reloadable by the host. Locations 32 to 48 are ROM with fixed sequences. Each location holds one step: a target register address, the data to write, a delay code and an end flag.

The host starts a replay by writing a start location into a trigger register on its normal register-write port. From then on the engine owns the register-file write port through a multiplexer. It issues one write per step, then waits a self-timed gap derived only from the main clock before fetching the next step. It stops after a step whose end flag is set, or after location 48. A busy output reports that a replay is running. Host register writes that arrive meanwhile are dropped, and a sticky error flag records them until the next accepted trigger.

Top module: `regseq_engine`

## Requirements
- R1: After reset, `seq_busy`, `seq_err` and `rf_wr_en` are all 0 while the host issues no write.
- R2: While idle, a host write to any register address other than the trigger address (default 8'hFF) appears on `rf_wr_en`/`rf_wr_addr`/`rf_wr_data` in the same cycle.
- R3: A load on the RAM port changes the step at `ram_ld_loc` only when the engine is idle and the location is below 32. Loads aimed at 32 to 48, or made while busy, leave memory unchanged. A step is packed as register address in bits [21:14], data in [13:5], delay code in [4:1] and end flag in bit 0.
- R4: A host write to the trigger address while idle, with data from 0 to 48, is not forwarded to the register file. In the next cycle `seq_busy` is 1 and the step at that location is written.
- R5: While busy, the register-file port carries only engine writes. Each host non-trigger write is dropped and sets `seq_err`, and `seq_err` returns to 0 in the cycle after the next accepted trigger.
- R6: After a step with delay code d that does not end the replay, exactly 2^d cycles pass with `rf_wr_en` at 0 before the next location's write.
- R7: After the write of a step whose end flag is 1, `seq_busy` is 0 in the next cycle and no further engine write follows.
- R8: If no end flag is met, the replay stops after writing location 48, and `seq_busy` is 0 in the next cycle.
- R9: A trigger write while busy is ignored and the running replay continues unchanged. A trigger with data above 48 is ignored.
- R10: ROM location 32+k (k from 0 to 16) holds register address 8'h40+k, data 7k+3, delay code k mod 3, and an end flag only for k = 8 and k = 12.
- R11: After reset, RAM location i holds register address i, data i, delay code i mod 2, and an end flag when i mod 8 = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; all timing is derived from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host register-write strobe |
| host_wr_addr | input | 8 | Host register address (trigger address starts a replay) |
| host_wr_data | input | 9 | Host write data (start location for a trigger) |
| ram_ld_en | input | 1 | RAM load strobe |
| ram_ld_loc | input | 6 | Location to load |
| ram_ld_entry | input | 22 | Packed step to store |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_addr | output | 8 | Register-file write address |
| rf_wr_data | output | 9 | Register-file write data |
| seq_busy | output | 1 | A replay is in progress |
| seq_err | output | 1 | Sticky flag: a host write was dropped during a replay |

## Verification
The assertions check on every cycle the local step rules: the gap counter counts down by one per cycle, an end flag or location 48 sends the engine idle, a trigger in the gap leaves the step pointer alone, a dropped host write raises the error flag, and an accepted load can be read back. Only the bench scenarios show whole-replay behaviour. These are the exact order and contents of writes from the RAM and ROM regions, the 2^d gap lengths seen at the ports, and the reset presets. They also cover loads made while busy or into ROM having no later effect, and the error flag clearing on the next accepted trigger.

// File: rtl/regseq_pkg.sv
package regseq_pkg;

   localparam int SEQ_REG_W  = 8;
   localparam int SEQ_DATA_W = 9;
   localparam int SEQ_DLY_W  = 4;
   localparam int SEQ_ENT_W  = SEQ_REG_W + SEQ_DATA_W + SEQ_DLY_W + 1;

   typedef struct packed {
      logic [SEQ_REG_W-1:0]  reg_addr;
      logic [SEQ_DATA_W-1:0] wdata;
      logic [SEQ_DLY_W-1:0]  dly;
      logic                  last;
   } seq_entry_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EXEC = 2'd1,
      ST_GAP  = 2'd2
   } seq_state_e;

   function automatic seq_entry_t rom_entry(input int k);
      seq_entry_t e;
      e.reg_addr = SEQ_REG_W'(8'h40 + k);
      e.wdata    = SEQ_DATA_W'(k * 7 + 3);
      e.dly      = SEQ_DLY_W'(k % 3);
      e.last     = (k == 8) || (k == 12);
      return e;
   endfunction

   function automatic seq_entry_t ram_preset(input int i);
      seq_entry_t e;
      e.reg_addr = SEQ_REG_W'(i);
      e.wdata    = SEQ_DATA_W'(i);
      e.dly      = SEQ_DLY_W'(i % 2);
      e.last     = (i % 8) == 7;
      return e;
   endfunction

endpackage

// File: rtl/regseq_store.sv
module regseq_store
   import regseq_pkg::*;
#(
   parameter int LOC_W     = 6,
   parameter int RAM_DEPTH = 32,
   parameter int ROM_DEPTH = 17,
   parameter bit RAM_INIT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic             ld_ok,
   input  logic [LOC_W-1:0] ld_loc,
   input  seq_entry_t       ld_ent,
   input  logic [LOC_W-1:0] rd_loc,
   output seq_entry_t       rd_ent
);

   localparam int RAM_IW = $clog2(RAM_DEPTH);

   seq_entry_t ram [RAM_DEPTH];
   seq_entry_t rom [ROM_DEPTH];
   logic       ld_take;

   for (genvar k = 0; k < ROM_DEPTH; k++) begin : g_rom
      assign rom[k] = rom_entry(k);
   end

   assign ld_take = ld_en && ld_ok && (ld_loc < LOC_W'(RAM_DEPTH));

   if (RAM_INIT) begin : g_preset
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= ram_preset(i);
         end else if (ld_take) begin
            ram[ld_loc[RAM_IW-1:0]] <= ld_ent;
         end
      end
   end else begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
         end else if (ld_take) begin
            ram[ld_loc[RAM_IW-1:0]] <= ld_ent;
         end
      end
   end

   always_comb begin
      rd_ent = '0;
      if (rd_loc < LOC_W'(RAM_DEPTH)) begin
         rd_ent = ram[rd_loc[RAM_IW-1:0]];
      end else begin
         for (int k = 0; k < ROM_DEPTH; k++) begin
            if (rd_loc == LOC_W'(RAM_DEPTH + k)) rd_ent = rom[k];
         end
      end
   end

   // R3: an accepted load is what the read port returns next cycle
   a_r3_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_take && rd_loc == ld_loc) |=>
         (rd_loc != $past(rd_loc) || rd_ent == $past(ld_ent)));

endmodule

// File: rtl/regseq_ctrl.sv
module regseq_ctrl
   import regseq_pkg::*;
#(
   parameter int LOC_W    = 6,
   parameter int LAST_LOC = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic [LOC_W-1:0] start_loc,
   input  seq_entry_t       cur_ent,
   output logic [LOC_W-1:0] cur_loc,
   output logic             busy,
   output logic             eng_we,
   output logic             start_take
);

   localparam int GAP_W = (1 << SEQ_DLY_W) - 1;

   seq_state_e       st;
   logic [GAP_W-1:0] gap;
   logic             at_top;

   assign at_top     = (cur_loc == LOC_W'(LAST_LOC));
   assign busy       = (st != ST_IDLE);
   assign eng_we     = (st == ST_EXEC);
   assign start_take = (st == ST_IDLE) && start_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cur_loc <= '0;
         gap     <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start_req) begin
                  st      <= ST_EXEC;
                  cur_loc <= start_loc;
               end
            end
            ST_EXEC: begin
               if (cur_ent.last || at_top) begin
                  st <= ST_IDLE;
               end else begin
                  st      <= ST_GAP;
                  gap     <= (GAP_W'(1) << cur_ent.dly) - GAP_W'(1);
                  cur_loc <= cur_loc + LOC_W'(1);
               end
            end
            ST_GAP: begin
               if (gap == '0) st <= ST_EXEC;
               else           gap <= gap - GAP_W'(1);
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r6_gap_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_GAP && gap != '0) |=> (st == ST_GAP && gap == $past(gap) - GAP_W'(1)));

   a_r7_end_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_EXEC && cur_ent.last) |=> !busy);

   a_r8_top_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_EXEC && at_top) |=> !busy);

   a_r9_busy_trigger_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_GAP && start_req) |=> (cur_loc == $past(cur_loc)));

endmodule

// File: rtl/regseq_busmux.sv
module regseq_busmux
   import regseq_pkg::*;
#(
   parameter bit ERR_ON_BUSY_TRIG = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  busy,
   input  logic                  start_take,
   input  logic                  host_we,
   input  logic                  host_is_trig,
   input  logic [SEQ_REG_W-1:0]  host_addr,
   input  logic [SEQ_DATA_W-1:0] host_data,
   input  logic                  eng_we,
   input  logic [SEQ_REG_W-1:0]  eng_addr,
   input  logic [SEQ_DATA_W-1:0] eng_data,
   output logic                  rf_we,
   output logic [SEQ_REG_W-1:0]  rf_addr,
   output logic [SEQ_DATA_W-1:0] rf_data,
   output logic                  err
);

   logic dropped;

   if (ERR_ON_BUSY_TRIG) begin : g_err_all
      assign dropped = busy && host_we;
   end else begin : g_err_regs
      assign dropped = busy && host_we && !host_is_trig;
   end

   always_comb begin
      if (busy) begin
         rf_we   = eng_we;
         rf_addr = eng_addr;
         rf_data = eng_data;
      end else begin
         rf_we   = host_we && !host_is_trig;
         rf_addr = host_addr;
         rf_data = host_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          err <= 1'b0;
      else if (dropped)    err <= 1'b1;
      else if (start_take) err <= 1'b0;
   end

   a_r5_drop_flags_error: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_we && !host_is_trig) |=> err);

endmodule

// File: rtl/regseq_engine.sv
module regseq_engine
   import regseq_pkg::*;
#(
   parameter int           LOC_W            = 6,
   parameter int           RAM_DEPTH        = 32,
   parameter int           ROM_DEPTH        = 17,
   parameter logic [7:0]   TRIG_ADDR        = 8'hFF,
   parameter bit           RAM_INIT         = 1'b1,
   parameter bit           ERR_ON_BUSY_TRIG = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_wr_en,
   input  logic [SEQ_REG_W-1:0]  host_wr_addr,
   input  logic [SEQ_DATA_W-1:0] host_wr_data,
   input  logic                  ram_ld_en,
   input  logic [LOC_W-1:0]      ram_ld_loc,
   input  logic [SEQ_ENT_W-1:0]  ram_ld_entry,
   output logic                  rf_wr_en,
   output logic [SEQ_REG_W-1:0]  rf_wr_addr,
   output logic [SEQ_DATA_W-1:0] rf_wr_data,
   output logic                  seq_busy,
   output logic                  seq_err
);

   localparam int LAST_LOC = RAM_DEPTH + ROM_DEPTH - 1;

   if (RAM_DEPTH + ROM_DEPTH > (1 << LOC_W)) begin : g_chk_span
      $error("regseq_engine: LOC_W too narrow for memory span");
   end
   if ((1 << $clog2(RAM_DEPTH)) != RAM_DEPTH) begin : g_chk_pow2
      $error("regseq_engine: RAM_DEPTH must be a power of two");
   end
   if (LOC_W > SEQ_DATA_W) begin : g_chk_trigw
      $error("regseq_engine: start location wider than trigger data");
   end

   logic             is_trig;
   logic             start_req;
   logic             start_take;
   logic             eng_we;
   logic [LOC_W-1:0] cur_loc;
   seq_entry_t       cur_ent;

   assign is_trig   = (host_wr_addr == TRIG_ADDR);
   assign start_req = host_wr_en && is_trig
                      && (host_wr_data <= SEQ_DATA_W'(LAST_LOC));

   regseq_store #(
      .LOC_W    (LOC_W),
      .RAM_DEPTH(RAM_DEPTH),
      .ROM_DEPTH(ROM_DEPTH),
      .RAM_INIT (RAM_INIT)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_en (ram_ld_en),
      .ld_ok (!seq_busy),
      .ld_loc(ram_ld_loc),
      .ld_ent(seq_entry_t'(ram_ld_entry)),
      .rd_loc(cur_loc),
      .rd_ent(cur_ent)
   );

   regseq_ctrl #(
      .LOC_W   (LOC_W),
      .LAST_LOC(LAST_LOC)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .start_loc (host_wr_data[LOC_W-1:0]),
      .cur_ent   (cur_ent),
      .cur_loc   (cur_loc),
      .busy      (seq_busy),
      .eng_we    (eng_we),
      .start_take(start_take)
   );

   regseq_busmux #(
      .ERR_ON_BUSY_TRIG(ERR_ON_BUSY_TRIG)
   ) u_mux (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy        (seq_busy),
      .start_take  (start_take),
      .host_we     (host_wr_en),
      .host_is_trig(is_trig),
      .host_addr   (host_wr_addr),
      .host_data   (host_wr_data),
      .eng_we      (eng_we),
      .eng_addr    (cur_ent.reg_addr),
      .eng_data    (cur_ent.wdata),
      .rf_we       (rf_wr_en),
      .rf_addr     (rf_wr_addr),
      .rf_data     (rf_wr_data),
      .err         (seq_err)
   );

endmodule

// File: tb/regseq_engine_test.sv
`timescale 1ns/1ps
module regseq_engine_test;

   localparam logic [7:0] TRIG = 8'hFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [7:0]  host_wr_addr = '0;
   logic [8:0]  host_wr_data = '0;
   logic        ram_ld_en = 1'b0;
   logic [5:0]  ram_ld_loc = '0;
   logic [21:0] ram_ld_entry = '0;
   logic        rf_wr_en;
   logic [7:0]  rf_wr_addr;
   logic [8:0]  rf_wr_data;
   logic        seq_busy;
   logic        seq_err;

   int n_chk = 0;
   int n_bad = 0;
   logic [21:0] model [49];
   bit exp_err = 1'b0;

   always #2.5 clk = ~clk;

   regseq_engine uut (
      .clk(clk), .rst_n(rst_n),
      .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
      .ram_ld_en(ram_ld_en), .ram_ld_loc(ram_ld_loc), .ram_ld_entry(ram_ld_entry),
      .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
      .seq_busy(seq_busy), .seq_err(seq_err)
   );

   function automatic logic [21:0] pack(input int a, input int d, input int g, input bit e);
      return {8'(a), 9'(d), 4'(g), e};
   endfunction

   function automatic logic [21:0] exp_rom(input int k);   // R10
      return pack(8'h40 + k, k * 7 + 3, k % 3, (k == 8) || (k == 12));
   endfunction

   function automatic logic [21:0] exp_ram(input int i);   // R11
      return pack(i, i, i % 2, (i % 8) == 7);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic load(input int loc, input logic [21:0] ent);
      @(negedge clk);
      ram_ld_en = 1'b1; ram_ld_loc = 6'(loc); ram_ld_entry = ent;
      @(negedge clk);
      ram_ld_en = 1'b0;
      if (loc < 32) model[loc] = ent;   // R3: ROM range untouched
   endtask

   // inject: 0 none, 1 host reg write in first gap, 2 trigger in first gap, 3 RAM load in first gap
   task automatic run_seq(input int start, input int inject);
      int  loc;
      bit  injected;
      logic [21:0] e;
      loc = start; injected = 1'b0;
      @(negedge clk);
      host_wr_en = 1'b1; host_wr_addr = TRIG; host_wr_data = 9'(start);
      #0.5;
      chk("R4 trigger not forwarded", rf_wr_en, 1'b0);
      @(negedge clk);
      host_wr_en = 1'b0;
      #0.5;
      chk("R4 busy after trigger", seq_busy, 1'b1);
      chk("R5 error cleared by trigger", seq_err, 1'b0);
      exp_err = 1'b0;
      forever begin
         e = model[loc];
         chk("R4 engine write strobe", rf_wr_en, 1'b1);
         chk(start >= 32 ? "R10 ROM addr" : "R11 RAM addr", rf_wr_addr, e[21:14]);
         chk(start >= 32 ? "R10 ROM data" : "R11 RAM data", rf_wr_data, e[13:5]);
         if (e[0] || loc == 48) begin
            @(negedge clk);
            #0.5;
            chk(e[0] ? "R7 idle after end flag" : "R8 idle after top", seq_busy, 1'b0);
            chk(e[0] ? "R7 no further write" : "R8 no further write", rf_wr_en, 1'b0);
            break;
         end
         for (int g = 0; g < (1 << e[4:1]); g++) begin
            @(negedge clk);
            host_wr_en = 1'b0; ram_ld_en = 1'b0;
            if (!injected && inject == 1) begin
               host_wr_en = 1'b1; host_wr_addr = 8'h21; host_wr_data = 9'h1AB;
               exp_err = 1'b1;
            end else if (!injected && inject == 2) begin
               host_wr_en = 1'b1; host_wr_addr = TRIG; host_wr_data = 9'd5;
            end else if (!injected && inject == 3) begin
               ram_ld_en = 1'b1; ram_ld_loc = 6'd1; ram_ld_entry = 22'h3FFFFF;
            end
            injected = 1'b1;
            #0.5;
            chk("R6 gap has no write", rf_wr_en, 1'b0);
            chk("R6 busy during gap", seq_busy, 1'b1);
         end
         @(negedge clk);
         host_wr_en = 1'b0; ram_ld_en = 1'b0;
         loc++;
         #0.5;
      end
      chk("R5 sticky error state", seq_err, exp_err);
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int unused;
      unused = $urandom(32'h5EED);
      for (int i = 0; i < 32; i++) model[i] = exp_ram(i);
      for (int k = 0; k < 17; k++) model[32 + k] = exp_rom(k);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #0.5;
      chk("R1 busy at reset", seq_busy, 1'b0);
      chk("R1 err at reset", seq_err, 1'b0);
      chk("R1 no write at reset", rf_wr_en, 1'b0);

      // R2 idle pass-through
      @(negedge clk);
      host_wr_en = 1'b1; host_wr_addr = 8'h12; host_wr_data = 9'h155;
      #0.5;
      chk("R2 pass strobe", rf_wr_en, 1'b1);
      chk("R2 pass addr", rf_wr_addr, 8'h12);
      chk("R2 pass data", rf_wr_data, 9'h155);
      @(negedge clk);
      host_wr_en = 1'b0;

      run_seq(0, 0);    // R11 presets
      run_seq(8, 0);    // R11 presets
      run_seq(32, 0);   // R10 first ROM sequence
      run_seq(41, 0);   // R10 second ROM sequence
      run_seq(45, 0);   // R8 runs off the top

      // R9 out-of-range trigger
      @(negedge clk);
      host_wr_en = 1'b1; host_wr_addr = TRIG; host_wr_data = 9'd50;
      @(negedge clk);
      host_wr_en = 1'b0;
      #0.5;
      chk("R9 out-of-range trigger ignored", seq_busy, 1'b0);

      // R3 loads into ROM range ignored
      load(42, 22'h2AAAAA);
      run_seq(41, 0);
      // R3 idle RAM load takes effect
      load(3, pack(8'hC3, 9'h0F0, 2, 1'b0));
      run_seq(2, 0);

      run_seq(32, 1);   // R5 host write dropped, error set
      run_seq(32, 2);   // R9 trigger while busy ignored
      run_seq(24, 3);   // R3 load while busy ignored
      run_seq(0, 0);    // R3 location 1 unchanged

      // constrained random mix
      for (int r = 0; r < 12; r++) begin
         for (int j = 0; j < 4; j++) begin
            int l = $urandom_range(0, 48);
            load(l, pack($urandom_range(0, 255), $urandom_range(0, 511),
                         $urandom_range(0, 3), ($urandom_range(0, 2) == 0)));
         end
         @(negedge clk);
         host_wr_en = 1'b1; host_wr_addr = 8'($urandom_range(0, 254));
         host_wr_data = 9'($urandom_range(0, 511));
         #0.5;
         chk("R2 random pass addr", rf_wr_addr, host_wr_addr);
         chk("R2 random pass strobe", rf_wr_en, 1'b1);
         @(negedge clk);
         host_wr_en = 1'b0;
         run_seq($urandom_range(0, 48), $urandom_range(0, 3));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule